// File: doc/BRIEF.md
# Event-Driven State Counter

This block is a prescaled up-counter whose actions are steered by a set of programmable events instead of fixed compare channels. A bank of match registers is compared against the count on every prescaled tick. Each event picks one match register and carries an eight-bit mask of the states in which it is allowed to fire. A firing event raises a sticky flag and can either load a new value into a five-bit state variable or add a value to it. Sequences of counter behaviour can therefore be built as small state machines.

Software or a neighbouring block drives it through a flat register port. A single-cycle write strobe carries an address and a data word. A separate read address returns its data one clock later. Match register 0 can act as the period limit. Every match register has a shadow value, which is copied in whenever the counter reaches its limit, unless the configuration asks for the values to be kept.

Top module: `esc_timer`

## Requirements
- R1: After reset the count, state variable, event flags and interrupt output are all zero, and the control word reads 0x4 (halted, prescale 0).
- R2: The counter advances only while control bit 1 (stop) and bit 2 (halt) are both zero. Setting stop freezes the count at its present value.
- R3: A control write with bit 3 set zeroes the count and the prescaler. If the same write leaves stop and halt at zero, counting resumes at once. Bit 3 always reads back as zero.
- R4: With the prescale field at control bits 12:5 holding N, the count advances once every N+1 clock cycles while running.
- R5: With configuration bit 17 set, a tick taken while the count equals match register 0 returns the count to zero. Otherwise the count wraps from all ones to zero.
- R6: An event fires only on a tick where the match register named by its control bits 3:0 equals the count. Its combine field (bits 13:12) must be 0 or 1. Values 2 and 3 need an I/O condition that this block lacks, so such an event never fires.
- R7: An event fires only when the bit of its state mask indexed by the current state variable is set. A state of 8 or more blocks every event.
- R8: A fired event with control bit 14 set loads its value field (bits 19:15) into the state. With bit 14 clear it adds the value, modulo 32.
- R9: When several events that fire on one tick change the state, the highest-numbered one decides the result.
- R10: Each event sets its own flag bit, which stays set until a 1 is written to that bit. The interrupt output is the registered OR of flags ANDed with the enable register.
- R11: With configuration bit 7 clear, every match register takes its reload value when the counter reaches its limit (auto-limit match or wrap). With bit 7 set, the match registers keep their values.
- R12: The read data is registered, one cycle after the read address. Register addresses: 0 configuration, 1 control, 2 count (read only), 3 state, 4 flags, 5 interrupt enable, 8+i match i, 16+i reload i, 24+i state mask i, 32+i event control i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |
| evt_o | output | N_EVT | Registered one-cycle pulse per fired event |

## Verification
The bench builds the block with an eight-bit counter and keeps the defaults of eight match registers, eight events and an eight-bit prescaler. The narrow counter puts the natural wrap at 256 ticks, so a few hundred cycles cover it. Auto-limit periods and prescale ratios are walked from a vector table. Directed runs then arrange events so that they chain through states, collide on one tick, overflow the state adder, meet a blocked state and use an I/O-only combine mode. Each of these cases is decided within a dozen counts.

// File: rtl/esc_pkg.sv
package esc_pkg;

  // control word fields
  localparam int CTL_STOP   = 1;
  localparam int CTL_HALT   = 2;
  localparam int CTL_CLR    = 3;
  localparam int CTL_PS_LSB = 5;

  // configuration word fields
  localparam int CFG_NORELOAD = 7;
  localparam int CFG_AUTOLIM  = 17;

  // geometry of the state machine
  localparam int STATE_W = 5;
  localparam int MASK_W  = 8;
  localparam int IDX_W   = 3;

  // scalar register addresses
  localparam int A_CFG   = 0;
  localparam int A_CTRL  = 1;
  localparam int A_COUNT = 2;
  localparam int A_STATE = 3;
  localparam int A_FLAG  = 4;
  localparam int A_IEN   = 5;

  // array blocks, eight entries each
  localparam int BLK_MATCH  = 1;
  localparam int BLK_RELOAD = 2;
  localparam int BLK_MASK   = 3;
  localparam int BLK_EVCTL  = 4;

  typedef enum logic [1:0] {
    CMB_OR    = 2'd0,
    CMB_MATCH = 2'd1,
    CMB_IO    = 2'd2,
    CMB_AND   = 2'd3
  } cmb_e;

  typedef struct packed {
    logic [3:0]         msel;
    cmb_e               mode;
    logic               load;
    logic [STATE_W-1:0] val;
  } evctl_t;

  function automatic evctl_t ev_decode(input logic [31:0] w);
    evctl_t r;
    r.msel = w[3:0];
    r.mode = cmb_e'(w[13:12]);
    r.load = w[14];
    r.val  = w[19:15];
    return r;
  endfunction

  function automatic logic [31:0] ev_encode(input evctl_t c);
    logic [31:0] w;
    w        = '0;
    w[3:0]   = c.msel;
    w[13:12] = c.mode;
    w[14]    = c.load;
    w[19:15] = c.val;
    return w;
  endfunction

endpackage

// File: rtl/esc_prescaler.sv
module esc_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);

  logic [PS_W-1:0] pcnt_q;

  // ">=" keeps the divider safe when the ratio is lowered mid-count
  assign tick_o = run_i && (pcnt_q >= ps_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i)  pcnt_q <= '0;
    else if (tick_o)   pcnt_q <= '0;
    else if (run_i)    pcnt_q <= pcnt_q + 1'b1;
  end

  a_r4_tick_restarts: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (pcnt_q == '0));

  a_r2_divider_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> $stable(pcnt_q));

endmodule

// File: rtl/esc_counter.sv
module esc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             autolim_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lim_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = autolim_i && (cnt_q == limit_i);
  assign lim_o    = tick_i && (at_limit || (&cnt_q));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (tick_i)   cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));

  a_r2_hold_count: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_q));

  a_r5_limit_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_i && at_limit && !clr_i) |=> (cnt_q == '0));

endmodule

// File: rtl/esc_event.sv
module esc_event
  import esc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 8
) (
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [CNT_W-1:0]   match_i [N_MATCH],
  input  logic [STATE_W-1:0] state_i,
  input  logic [MASK_W-1:0]  mask_i,
  input  evctl_t             ctl_i,
  output logic               fire_o,
  output logic               load_o,
  output logic [STATE_W-1:0] val_o
);

  logic hit;
  logic st_en;
  logic mode_ok;

  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < N_MATCH; j++) begin
      if ((ctl_i.msel == 4'(j)) && (match_i[j] == cnt_i)) hit = 1'b1;
    end
  end

  // states beyond the mask width can never enable an event
  assign st_en   = (state_i[STATE_W-1:IDX_W] == '0) && mask_i[state_i[IDX_W-1:0]];
  // no I/O conditions exist here: OR reduces to the match term, I/O and AND never hold
  assign mode_ok = (ctl_i.mode == CMB_OR) || (ctl_i.mode == CMB_MATCH);

  assign fire_o = tick_i && hit && st_en && mode_ok;
  assign load_o = ctl_i.load;
  assign val_o  = ctl_i.val;

endmodule

// File: rtl/esc_timer.sv
module esc_timer
  import esc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 8,
  parameter int N_EVT   = 8,
  parameter int PS_W    = 8,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic [N_EVT-1:0]  evt_o
);

  localparam int BLK_W = ADDR_W - IDX_W;

  // configuration and control
  logic              noreload_q, autolim_q;
  logic              stop_q, halt_q;
  logic [PS_W-1:0]   ps_q;
  logic [STATE_W-1:0] state_q, st_nxt;
  logic [N_EVT-1:0]  flag_q, ien_q, w1c;
  logic [CNT_W-1:0]  match_q  [N_MATCH];
  logic [CNT_W-1:0]  reload_q [N_MATCH];
  logic [MASK_W-1:0] mask_q   [N_EVT];
  evctl_t            evctl_q  [N_EVT];

  logic              run, clr, tick, lim, reload_now;
  logic [CNT_W-1:0]  cnt;
  logic [N_EVT-1:0]  fire, ev_load;
  logic [STATE_W-1:0] ev_val [N_EVT];
  logic              st_wr;
  logic [DATA_W-1:0] rd_nxt;

  logic [BLK_W-1:0]  wr_blk, rd_blk;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_unused;

  assign wr_blk    = wr_addr[ADDR_W-1:IDX_W];
  assign wr_idx    = wr_addr[IDX_W-1:0];
  assign rd_blk    = rd_addr[ADDR_W-1:IDX_W];
  assign rd_idx    = rd_addr[IDX_W-1:0];
  assign wr_unused = &{1'b0, wr_data};

  assign run        = !stop_q && !halt_q;
  assign clr        = wr_en && (wr_addr == ADDR_W'(A_CTRL)) && wr_data[CTL_CLR];
  assign st_wr      = wr_en && (wr_addr == ADDR_W'(A_STATE));
  assign w1c        = (wr_en && (wr_addr == ADDR_W'(A_FLAG))) ? wr_data[N_EVT-1:0] : '0;
  assign reload_now = lim && !noreload_q;

  // ------------------------------------------------------------------
  // datapath
  esc_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .clr_i(clr), .run_i(run), .ps_i(ps_q), .tick_o(tick)
  );

  esc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(clr), .tick_i(tick), .autolim_i(autolim_q),
    .limit_i(match_q[0]), .cnt_o(cnt), .lim_o(lim)
  );

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    esc_event #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_ev (
      .tick_i(tick), .cnt_i(cnt), .match_i(match_q), .state_i(state_q),
      .mask_i(mask_q[i]), .ctl_i(evctl_q[i]),
      .fire_o(fire[i]), .load_o(ev_load[i]), .val_o(ev_val[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[i]  <= '0;
        evctl_q[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        if (wr_blk == BLK_W'(BLK_MASK))  mask_q[i]  <= wr_data[MASK_W-1:0];
        if (wr_blk == BLK_W'(BLK_EVCTL)) evctl_q[i] <= ev_decode(32'(wr_data));
      end
    end
  end

  // ------------------------------------------------------------------
  // match and shadow registers
  for (genvar j = 0; j < N_MATCH; j++) begin : g_match
    always_ff @(posedge clk) begin
      if (rst)
        match_q[j] <= '0;
      else if (wr_en && (wr_blk == BLK_W'(BLK_MATCH)) && (wr_idx == IDX_W'(j)))
        match_q[j] <= wr_data[CNT_W-1:0];
      else if (reload_now)
        match_q[j] <= reload_q[j];
    end

    always_ff @(posedge clk) begin
      if (rst)
        reload_q[j] <= '0;
      else if (wr_en && (wr_blk == BLK_W'(BLK_RELOAD)) && (wr_idx == IDX_W'(j)))
        reload_q[j] <= wr_data[CNT_W-1:0];
    end
  end

  // ------------------------------------------------------------------
  // configuration and control words
  always_ff @(posedge clk) begin
    if (rst) begin
      noreload_q <= 1'b0;
      autolim_q  <= 1'b0;
      stop_q     <= 1'b0;
      halt_q     <= 1'b1;
      ps_q       <= '0;
      ien_q      <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CFG)) begin
        noreload_q <= wr_data[CFG_NORELOAD];
        autolim_q  <= wr_data[CFG_AUTOLIM];
      end
      if (wr_addr == ADDR_W'(A_CTRL)) begin
        stop_q <= wr_data[CTL_STOP];
        halt_q <= wr_data[CTL_HALT];
        ps_q   <= wr_data[CTL_PS_LSB +: PS_W];
      end
      if (wr_addr == ADDR_W'(A_IEN)) ien_q <= wr_data[N_EVT-1:0];
    end
  end

  // ------------------------------------------------------------------
  // state resolution: later (higher-numbered) events overwrite earlier ones
  always_comb begin
    st_nxt = state_q;
    for (int i = 0; i < N_EVT; i++) begin
      if (fire[i]) st_nxt = ev_load[i] ? ev_val[i] : state_q + ev_val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        state_q <= '0;
    else if (st_wr) state_q <= wr_data[STATE_W-1:0];
    else            state_q <= st_nxt;
  end

  // sticky flags, interrupt and event pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_o  <= 1'b0;
      evt_o  <= '0;
    end else begin
      flag_q <= (flag_q & ~w1c) | fire;
      irq_o  <= |(flag_q & ien_q);
      evt_o  <= fire;
    end
  end

  // ------------------------------------------------------------------
  // registered read port
  always_comb begin
    rd_nxt = '0;
    case (rd_blk)
      BLK_W'(0): begin
        case (rd_idx)
          IDX_W'(A_CFG): begin
            rd_nxt[CFG_NORELOAD] = noreload_q;
            rd_nxt[CFG_AUTOLIM]  = autolim_q;
          end
          IDX_W'(A_CTRL): begin
            rd_nxt[CTL_STOP]              = stop_q;
            rd_nxt[CTL_HALT]              = halt_q;
            rd_nxt[CTL_PS_LSB +: PS_W]    = ps_q;
          end
          IDX_W'(A_COUNT): rd_nxt[CNT_W-1:0]   = cnt;
          IDX_W'(A_STATE): rd_nxt[STATE_W-1:0] = state_q;
          IDX_W'(A_FLAG):  rd_nxt[N_EVT-1:0]   = flag_q;
          IDX_W'(A_IEN):   rd_nxt[N_EVT-1:0]   = ien_q;
          default:         rd_nxt = '0;
        endcase
      end
      BLK_W'(BLK_MATCH):  if (32'(rd_idx) < N_MATCH) rd_nxt[CNT_W-1:0]  = match_q[rd_idx];
      BLK_W'(BLK_RELOAD): if (32'(rd_idx) < N_MATCH) rd_nxt[CNT_W-1:0]  = reload_q[rd_idx];
      BLK_W'(BLK_MASK):   if (32'(rd_idx) < N_EVT)   rd_nxt[MASK_W-1:0] = mask_q[rd_idx];
      BLK_W'(BLK_EVCTL):  if (32'(rd_idx) < N_EVT)   rd_nxt = DATA_W'(ev_encode(evctl_q[rd_idx]));
      default:            rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  // ------------------------------------------------------------------
  a_r6_no_fire_off_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |-> (fire == '0));

  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    (w1c == '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r9_state_hold: assert property (@(posedge clk) disable iff (rst)
    ((fire == '0) && !st_wr) |=> $stable(state_q));

  a_r11_keep_match: assert property (@(posedge clk) disable iff (rst)
    (noreload_q && !(wr_en && (wr_blk == BLK_W'(BLK_MATCH)) && (wr_idx == '0)))
      |=> $stable(match_q[0]));

endmodule

// File: tb/sim_esc_timer.sv
module sim_esc_timer;

  localparam int CW = 8;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NE = 8;

  localparam logic [AW-1:0] R_CFG = 6'd0, R_CTRL = 6'd1, R_CNT = 6'd2,
                            R_ST = 6'd3, R_FLG = 6'd4, R_IEN = 6'd5;
  localparam logic [AW-1:0] R_M0 = 6'd8, R_RL0 = 6'd16, R_MK0 = 6'd24, R_EC0 = 6'd32;

  localparam logic [31:0] CF_NORL = 32'h80, CF_AL = 32'h20000;
  localparam logic [31:0] CT_STOP = 32'h2, CT_HALT = 32'h4, CT_CLR = 32'h8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_o;
  logic [NE-1:0] evt_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  esc_timer #(.CNT_W(CW), .N_MATCH(8), .N_EVT(NE), .PS_W(8), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .evt_o(evt_o)
  );

  typedef struct packed {
    logic [7:0]  ps;
    logic [15:0] nw;
    logic        al;
    logic [7:0]  m0;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd0, 16'd9,   1'b0, 8'd0},
    '{8'd3, 16'd19,  1'b0, 8'd0},
    '{8'd1, 16'd10,  1'b0, 8'd0},
    '{8'd0, 16'd12,  1'b1, 8'd4},
    '{8'd2, 16'd14,  1'b1, 8'd2},
    '{8'd0, 16'd299, 1'b0, 8'd0}
  };

  function automatic logic [31:0] exp_count(vec_t v);
    int ticks;
    ticks = (int'(v.nw) + 1) / (int'(v.ps) + 1);
    if (v.al) return 32'(ticks % (int'(v.m0) + 1));
    return 32'(ticks % (2 ** CW));
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // start from zero, let nw more edges pass, then halt on the following edge
  task automatic run_for(input logic [7:0] ps, input int nw);
    wr(R_CTRL, (32'(ps) << 5) | CT_CLR);
    repeat (nw) @(negedge clk);
    wr(R_CTRL, (32'(ps) << 5) | CT_HALT);
  endtask

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(R_CTRL, d); chk("R1 control", d, 32'h4);
    rd(R_CNT, d);  chk("R1 count", d, 32'h0);
    rd(R_ST, d);   chk("R1 state", d, 32'h0);
    rd(R_FLG, d);  chk("R1 flags", d, 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);

    // R4 R5 R11 vector table: prescale ratios, auto-limit periods, natural wrap
    foreach (VECS[k]) begin
      do_reset();
      wr(R_CFG, CF_NORL | (VECS[k].al ? CF_AL : 32'h0));
      wr(R_M0, 32'(VECS[k].m0));
      run_for(VECS[k].ps, int'(VECS[k].nw));
      rd(R_CNT, d);
      chk($sformatf("R4/R5 vector %0d count", k), d, exp_count(VECS[k]));
      if (VECS[k].al) begin
        rd(R_M0, d);
        chk($sformatf("R11 vector %0d match kept", k), d, 32'(VECS[k].m0));
      end
    end

    // R12 configuration read back
    rd(R_CFG, d); chk("R12 config readback", d, CF_NORL);

    // R2 stop pauses, R3 restart clears and resumes
    do_reset();
    wr(R_CFG, CF_NORL);
    wr(R_CTRL, CT_CLR);
    repeat (4) @(negedge clk);
    wr(R_CTRL, CT_STOP);
    rd(R_CNT, d); chk("R2 stopped count", d, 32'd5);
    repeat (10) @(negedge clk);
    rd(R_CNT, d); chk("R2 count held while stopped", d, 32'd5);
    rd(R_CTRL, d); chk("R3 clear bit reads zero", d, CT_STOP);
    wr(R_CTRL, CT_CLR);
    repeat (2) @(negedge clk);
    wr(R_CTRL, CT_HALT);
    rd(R_CNT, d); chk("R3 restart from zero", d, 32'd3);

    // R6 R7 R8 R10: chained events through states 0 -> 2 -> 5 -> 17
    do_reset();
    wr(R_CFG, CF_NORL | CF_AL);
    wr(R_M0, 32'd9);
    wr(R_M0 + 6'd1, 32'd3);
    wr(R_M0 + 6'd2, 32'd5);
    wr(R_M0 + 6'd4, 32'd7);
    wr(R_M0 + 6'd6, 32'd8);
    wr(R_MK0 + 6'd0, 32'h01); wr(R_EC0 + 6'd0, 32'h15001);  // m1, match, load 2
    wr(R_MK0 + 6'd1, 32'h04); wr(R_EC0 + 6'd1, 32'h19002);  // m2, match, add 3
    wr(R_MK0 + 6'd2, 32'h02); wr(R_EC0 + 6'd2, 32'h3D001);  // state 1 only
    wr(R_MK0 + 6'd3, 32'hFF); wr(R_EC0 + 6'd3, 32'h3E001);  // I/O-only mode
    wr(R_MK0 + 6'd4, 32'h20); wr(R_EC0 + 6'd4, 32'h8C004);  // m4, OR mode, load 17
    wr(R_MK0 + 6'd5, 32'hFF); wr(R_EC0 + 6'd5, 32'h0D006);  // m6 at state 17
    run_for(8'd0, 8);
    rd(R_CNT, d); chk("R6 count at halt", d, 32'd9);
    rd(R_ST, d);  chk("R8 chained state", d, 32'd17);
    rd(R_FLG, d); chk("R6/R7 flags fired set", d, 32'h13);
    chk("R10 irq masked", 32'(irq_o), 32'h0);
    wr(R_IEN, 32'h02);
    @(negedge clk);
    chk("R10 irq enabled", 32'(irq_o), 32'h1);
    wr(R_FLG, 32'h02);
    @(negedge clk);
    chk("R10 irq after clear", 32'(irq_o), 32'h0);
    rd(R_FLG, d); chk("R10 write one clears", d, 32'h11);

    // R9 two events on one tick, higher index wins
    do_reset();
    wr(R_CFG, CF_NORL);
    wr(R_M0 + 6'd1, 32'd2);
    wr(R_MK0 + 6'd0, 32'hFF); wr(R_EC0 + 6'd0, 32'h3D001);  // load 7
    wr(R_MK0 + 6'd1, 32'hFF); wr(R_EC0 + 6'd1, 32'h4D001);  // load 9
    run_for(8'd0, 3);
    rd(R_ST, d); chk("R9 highest event wins", d, 32'd9);

    // R8 addition wraps modulo 32
    do_reset();
    wr(R_CFG, CF_NORL);
    wr(R_ST, 32'd5);
    wr(R_M0 + 6'd1, 32'd2);
    wr(R_MK0 + 6'd0, 32'h20); wr(R_EC0 + 6'd0, 32'hF1001);  // add 30
    run_for(8'd0, 3);
    rd(R_ST, d); chk("R8 add wraps", d, 32'd3);

    // R11 shadow reload at the limit
    do_reset();
    wr(R_CFG, CF_AL);
    wr(R_M0, 32'd3);
    wr(R_RL0, 32'd6);
    run_for(8'd0, 9);
    rd(R_CNT, d); chk("R11 count with reloaded limit", d, 32'd6);
    rd(R_M0, d);  chk("R11 match took reload", d, 32'd6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule